// File: doc/BRIEF.md
# Task-File Configuration Window Unlock

This block sits between a host register bus and the eight-offset command-block register file of an IDE channel. Normally every host access passes straight through to the task-file registers. The block also watches the accesses for a short handshake. That handshake is two word-sized reads of offset 1, then a byte write of 0x03 to offset 2. When the handshake completes, the low offsets stop reaching the task file and instead reach a hidden bank of controller configuration registers.

The hidden bank holds the following registers. Two timing registers, one for read cycles and one for write cycles, each carry a command pulse width and a recovery time. A control register switches the controller on or off using two magic values. A read-only strap reflects the bus speed. A miscellaneous register carries the drive select, a delay, an address setup count and a read-prefetch enable. A byte write of 0x83 to offset 2 hides the bank again. The timing and miscellaneous fields are exported as ports, so that a cycle generator can use them.

Host reads return data in the same cycle, with no register in the path. Writes into the bank, and every state change of the detector, take effect at the next rising clock edge.

Top module: `tfcw_window`

## Requirements
- R1: After reset the bank is hidden (`bank_open`=0). Both timing registers read 0xFF, so pulse and recovery are all ones. The control register reads 0x11 with `ctl_enabled`=0. The miscellaneous register reads 0x00.
- R2: Two word-sized (`host_wide`=1) reads of offset 1 open the bank when they are followed by a byte-sized write of 0x03 to offset 2. `bank_open` rises at the clock edge that takes that write.
- R3: While the bank is hidden, every host access is forwarded to the task file, including the accesses that form the handshake. The strobes, address, size and write data are copied over, and `host_rdata` equals `tf_rdata`.
- R4: While the bank is hidden, certain accesses abort the handshake, and a following 0x03 write then does not open the bank. The aborting accesses are: a byte read of offset 1, an access to any other offset, a byte write to offset 2 of a value other than 0x03, and a word write to offset 2. The aborting access is still forwarded.
- R5: A third or later word read of offset 1 leaves the detector armed, so a 0x03 write that follows still opens the bank.
- R6: While the bank is open, accesses to offsets 0, 1, 3, 4, 5 and 6 raise neither `tf_rd` nor `tf_wr`. Accesses to offsets 2 and 7 are still forwarded.
- R7: Offset 0 is the read timing register and offset 1 is the write timing register. In each one, bits 3:0 are the recovery time and bits 7:4 are the command pulse width. The fields appear on `rd_recovery`/`rd_pulse` and on `wr_recovery`/`wr_pulse`, and read back unchanged.
- R8: At offset 3, writing 0x95 sets `ctl_enabled` and writing 0x11 clears it. Any other value has no effect. The register reads 0x95 when enabled and 0x11 when disabled.
- R9: Offset 5 reads `strap_slow` in bit 0 and zero in all other bits. In that bit, 0 means a 33 MHz bus and 1 means a 25 MHz bus. Writes to offset 5 have no effect.
- R10: Writes to offset 6 keep only bits 6:0. Bit 0 appears on `drive_sel`, bits 3:1 on `cmd_delay`, bits 5:4 on `addr_setup` and bit 6 on `prefetch_en`. Reads return the masked value.
- R11: While the bank is open, a byte write of 0x83 to offset 2 hides the bank at that edge. Other writes to offset 2 leave it open and are forwarded.
- R12: Register contents survive a hide followed by a new handshake. Offset 4 of the open bank reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Register offset of the host access |
| host_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| tf_addr | output | ADDR_W | Offset toward the task file |
| tf_wide | output | 1 | Size toward the task file |
| tf_rd | output | 1 | Forwarded read strobe |
| tf_wr | output | 1 | Forwarded write strobe |
| tf_wdata | output | DATA_W | Forwarded write data |
| tf_rdata | input | DATA_W | Task-file read data |
| strap_slow | input | 1 | Bus speed strap, 1 = 25 MHz |
| bank_open | output | 1 | Configuration bank visible |
| rd_recovery | output | 4 | Read cycle recovery time |
| rd_pulse | output | 4 | Read cycle command pulse width |
| wr_recovery | output | 4 | Write cycle recovery time |
| wr_pulse | output | 4 | Write cycle command pulse width |
| ctl_enabled | output | 1 | Controller enabled |
| drive_sel | output | 1 | Drive select |
| cmd_delay | output | 3 | Delay count |
| addr_setup | output | 2 | Address setup count |
| prefetch_en | output | 1 | Read prefetch enable |

## Verification
The bench tries several near-miss handshakes. These are a byte read in place of a word read, a foreign offset, a wrong key value, and a word-sized key write. A detector that fails to return to idle would open the bank on the 0x03 write that follows. It also sends a third probe read, which a strict two-count detector would wrongly reject. Inside the open bank, it writes non-key values to the control register and to offset 2. It writes all ones to the miscellaneous register and to the strap. A design that wrongly forwards bank accesses, stores unmasked bits, or closes on any offset-2 write shows up at the strobes, the fields or the read data. Finally, it reopens the bank and reads back the old values, which catches a design that clears its registers on close.

// File: rtl/tfcw_pkg.sv
package tfcw_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ONE, SEQ_TWO, SEQ_OPEN} seq_state_e;

  localparam int unsigned OFS_PROBE = 1;
  localparam int unsigned OFS_KEY   = 2;
  localparam int unsigned OFS_CTRL  = 3;
  localparam int unsigned OFS_STRAP = 5;
  localparam int unsigned OFS_MISC  = 6;
  localparam int unsigned OFS_LAST  = 6;
  localparam int unsigned N_TIMING  = 2;

  localparam logic [7:0] KEY_OPEN  = 8'h03;
  localparam logic [7:0] KEY_CLOSE = 8'h83;
  localparam logic [7:0] CTRL_ON   = 8'h95;
  localparam logic [7:0] CTRL_OFF  = 8'h11;
  localparam logic [7:0] MISC_MASK = 8'h7F;
  localparam logic [7:0] TIM_SLOW  = 8'hFF;
endpackage

// File: rtl/tfcw_rst_sync.sv
module tfcw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/tfcw_unlock_fsm.sv
module tfcw_unlock_fsm
  import tfcw_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic              acc_wide,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_byte,
  output logic              open_o
);
  seq_state_e state_q, state_d;
  logic       probe_hit, key_byte_wr, open_key, close_key;

  assign probe_hit   = acc_rd && acc_wide && (acc_addr == ADDR_W'(OFS_PROBE));
  assign key_byte_wr = acc_wr && !acc_wide && (acc_addr == ADDR_W'(OFS_KEY));
  assign open_key    = key_byte_wr && (acc_byte == KEY_OPEN);
  assign close_key   = key_byte_wr && (acc_byte == KEY_CLOSE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_OPEN: if (close_key) state_d = SEQ_IDLE;
      default: begin
        if (acc_rd || acc_wr) begin
          if (probe_hit)
            state_d = (state_q == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
          else if (state_q == SEQ_TWO && open_key)
            state_d = SEQ_OPEN;
          else
            state_d = SEQ_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == SEQ_OPEN);
endmodule

// File: rtl/tfcw_cfg_bank.sv
module tfcw_cfg_bank
  import tfcw_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  input  logic              strap_slow,
  output logic [7:0]        rbyte,
  output logic [7:0]        rd_tim,
  output logic [7:0]        wr_tim,
  output logic              ctl_on,
  output logic [6:0]        misc
);
  logic [7:0] tim_q [N_TIMING];
  logic       ctl_q, ctl_d, ctl_en;
  logic [6:0] misc_q, misc_d;
  logic       misc_en;

  for (genvar g = 0; g < N_TIMING; g++) begin : g_tim
    logic tim_en;
    assign tim_en = wr_en && (addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tim_q[g] <= TIM_SLOW;
      else if (tim_en) tim_q[g] <= wbyte;
    end
  end

  always_comb begin
    ctl_en = wr_en && (addr == ADDR_W'(OFS_CTRL)) &&
             (wbyte == CTRL_ON || wbyte == CTRL_OFF);
    ctl_d  = (wbyte == CTRL_ON);
    misc_en = wr_en && (addr == ADDR_W'(OFS_MISC));
    misc_d  = wbyte[6:0] & MISC_MASK[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= 1'b0;
      misc_q <= '0;
    end else begin
      if (ctl_en)  ctl_q  <= ctl_d;
      if (misc_en) misc_q <= misc_d;
    end
  end

  always_comb begin
    rbyte = 8'h00;
    if (addr == ADDR_W'(0))              rbyte = tim_q[0];
    else if (addr == ADDR_W'(1))         rbyte = tim_q[1];
    else if (addr == ADDR_W'(OFS_CTRL))  rbyte = ctl_q ? CTRL_ON : CTRL_OFF;
    else if (addr == ADDR_W'(OFS_STRAP)) rbyte = {7'd0, strap_slow};
    else if (addr == ADDR_W'(OFS_MISC))  rbyte = {1'b0, misc_q};
  end

  assign rd_tim = tim_q[0];
  assign wr_tim = tim_q[1];
  assign ctl_on = ctl_q;
  assign misc   = misc_q;
endmodule

// File: rtl/tfcw_window.sv
module tfcw_window
  import tfcw_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wide,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] tf_addr,
  output logic              tf_wide,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] tf_rdata,
  input  logic              strap_slow,
  output logic              bank_open,
  output logic [3:0]        rd_recovery,
  output logic [3:0]        rd_pulse,
  output logic [3:0]        wr_recovery,
  output logic [3:0]        wr_pulse,
  output logic              ctl_enabled,
  output logic              drive_sel,
  output logic [2:0]        cmd_delay,
  output logic [1:0]        addr_setup,
  output logic              prefetch_en
);
  localparam int unsigned PAD_W = DATA_W - 8;

  logic       rst_q_n;
  logic       open_w, bank_hit, bank_wr;
  logic [7:0] bank_rbyte, rd_tim, wr_tim;
  logic [6:0] misc;

  tfcw_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  tfcw_unlock_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk(clk), .rst_n(rst_q_n), .acc_rd(host_rd), .acc_wr(host_wr),
    .acc_wide(host_wide), .acc_addr(host_addr), .acc_byte(host_wdata[7:0]),
    .open_o(open_w)
  );

  always_comb begin
    bank_hit = open_w && (host_addr <= ADDR_W'(OFS_LAST)) &&
               (host_addr != ADDR_W'(OFS_KEY));
    bank_wr  = bank_hit && host_wr;
  end

  tfcw_cfg_bank #(.ADDR_W(ADDR_W)) i_bank (
    .clk(clk), .rst_n(rst_q_n), .wr_en(bank_wr), .addr(host_addr),
    .wbyte(host_wdata[7:0]), .strap_slow(strap_slow), .rbyte(bank_rbyte),
    .rd_tim(rd_tim), .wr_tim(wr_tim), .ctl_on(ctl_enabled), .misc(misc)
  );

  assign tf_addr    = host_addr;
  assign tf_wide    = host_wide;
  assign tf_wdata   = host_wdata;
  assign tf_rd      = host_rd && !bank_hit;
  assign tf_wr      = host_wr && !bank_hit;
  assign host_rdata = bank_hit ? {{PAD_W{1'b0}}, bank_rbyte} : tf_rdata;

  assign bank_open   = open_w;
  assign rd_recovery = rd_tim[3:0];
  assign rd_pulse    = rd_tim[7:4];
  assign wr_recovery = wr_tim[3:0];
  assign wr_pulse    = wr_tim[7:4];
  assign drive_sel   = misc[0];
  assign cmd_delay   = misc[3:1];
  assign addr_setup  = misc[5:4];
  assign prefetch_en = misc[6];
endmodule

// File: rtl/tfcw_window_chk.sv
module tfcw_window_chk #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wide,
  input logic              host_rd,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic [DATA_W-1:0] tf_rdata,
  input logic              tf_rd,
  input logic              tf_wr,
  input logic              strap_slow,
  input logic              bank_open,
  input logic [3:0]        rd_recovery,
  input logic              ctl_enabled
);
  assert_open_by_key_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(bank_open) |-> $past(host_wr && !host_wide && host_addr == ADDR_W'(2)
                               && host_wdata[7:0] == 8'h03));

  assert_hidden_fwd_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!bank_open && host_rd) |-> (tf_rd && host_rdata == tf_rdata));

  assert_bank_quiet_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bank_open && (host_rd || host_wr) && host_addr <= ADDR_W'(6)
     && host_addr != ADDR_W'(2)) |-> (!tf_rd && !tf_wr));

  assert_rd_tim_hold_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$past(bank_open && host_wr && host_addr == ADDR_W'(0)) |-> $stable(rd_recovery));

  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$past(bank_open && host_wr && host_addr == ADDR_W'(3)) |-> $stable(ctl_enabled));

  assert_strap_read_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bank_open && host_rd && host_addr == ADDR_W'(5)) |->
      (host_rdata == {{(DATA_W-1){1'b0}}, strap_slow}));

  assert_close_by_key_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(bank_open) |-> $past(host_wr && !host_wide && host_addr == ADDR_W'(2)
                               && host_wdata[7:0] == 8'h83));
endmodule

bind tfcw_window tfcw_window_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_q_n(rst_q_n), .host_addr(host_addr), .host_wide(host_wide),
  .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .tf_rdata(tf_rdata), .tf_rd(tf_rd), .tf_wr(tf_wr),
  .strap_slow(strap_slow), .bank_open(bank_open), .rd_recovery(rd_recovery),
  .ctl_enabled(ctl_enabled)
);

// File: tb/test_tfcw_window.sv
`timescale 1ns/100ps
module test_tfcw_window;
  localparam int AW = 3;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] host_addr;
  logic          host_wide, host_rd, host_wr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic [AW-1:0] tf_addr;
  logic          tf_wide, tf_rd, tf_wr;
  logic [DW-1:0] tf_wdata, tf_rdata;
  logic          strap_slow;
  logic          bank_open;
  logic [3:0]    rd_recovery, rd_pulse, wr_recovery, wr_pulse;
  logic          ctl_enabled, drive_sel, prefetch_en;
  logic [2:0]    cmd_delay;
  logic [1:0]    addr_setup;

  typedef struct {
    logic          fwd;
    logic          chk;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign tf_rdata = 16'hA500 | {13'd0, tf_addr};

  tfcw_window #(.ADDR_W(AW), .DATA_W(DW)) i_tfcw_window (.*);

  // monitor: compares each access against the scoreboard
  always @(negedge clk) begin
    #2;
    if (host_rd || host_wr) begin
      if (exp_q.size() == 0) begin
        nerr++;
        $display("FAIL scoreboard empty: actual access, expected none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        nchk++;
        if ((tf_rd | tf_wr) !== e.fwd || (e.chk && host_rdata !== e.data)) begin
          nerr++;
          $display("FAIL %s: actual fwd=%0b data=%h, expected fwd=%0b data=%h",
                   e.tag, tf_rd | tf_wr, host_rdata, e.fwd, e.data);
        end
      end
    end
  end

  task automatic acc(input bit rd, input bit wide, input int a, input logic [DW-1:0] wd,
                     input bit fwd, input logic [DW-1:0] ed, input string tag);
    exp_t e;
    @(negedge clk);
    host_rd = rd; host_wr = !rd; host_wide = wide;
    host_addr = AW'(a); host_wdata = wd;
    e.fwd = fwd; e.chk = rd; e.data = ed; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic settle();
    @(negedge clk);
    host_rd = 0; host_wr = 0;
    #2;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] expv, input string tag);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s: actual %h, expected %h", tag, act, expv);
    end
  endtask

  task automatic unlock(input string tag);
    acc(1, 1, 1, 0, 1, 16'hA501, tag);
    acc(1, 1, 1, 0, 1, 16'hA501, tag);
    acc(0, 0, 2, 16'h0003, 1, 0, tag);
    settle();
  endtask

  initial begin
    rst_n = 0; host_rd = 0; host_wr = 0; host_wide = 0;
    host_addr = 0; host_wdata = 0; strap_slow = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #2;
    chk({15'd0, bank_open}, 0, "R1 bank hidden");
    chk({8'd0, rd_pulse, rd_recovery}, 16'h00FF, "R1 read timing");
    chk({8'd0, wr_pulse, wr_recovery}, 16'h00FF, "R1 write timing");
    chk({15'd0, ctl_enabled}, 0, "R1 ctl off");
    chk({9'd0, prefetch_en, addr_setup, cmd_delay, drive_sel}, 0, "R1 misc");

    acc(1, 0, 1, 0, 1, 16'hA501, "R3 byte read forwarded");
    acc(0, 1, 4, 16'h1234, 1, 0, "R3 write forwarded");
    unlock("R3 handshake forwarded");
    chk({15'd0, bank_open}, 1, "R2 opened");

    acc(1, 0, 0, 0, 0, 16'h00FF, "R1 R7 read timing reg");
    acc(1, 0, 3, 0, 0, 16'h0011, "R1 R8 control reset");
    acc(1, 0, 6, 0, 0, 16'h0000, "R1 R10 misc reset");
    acc(1, 0, 4, 0, 0, 16'h0000, "R12 spare reads 0");
    acc(1, 0, 5, 0, 0, 16'h0001, "R9 strap slow");
    acc(1, 1, 7, 0, 1, 16'hA507, "R6 offset 7 forwarded");
    acc(1, 0, 2, 0, 1, 16'hA502, "R6 offset 2 forwarded");

    acc(0, 0, 0, 16'h003A, 0, 0, "R7 write rd timing");
    acc(0, 0, 1, 16'h00C5, 0, 0, "R7 write wr timing");
    settle();
    chk({8'd0, rd_pulse, rd_recovery}, 16'h003A, "R7 rd fields");
    chk({8'd0, wr_pulse, wr_recovery}, 16'h00C5, "R7 wr fields");
    acc(1, 0, 0, 0, 0, 16'h003A, "R7 rd readback");
    acc(1, 1, 1, 0, 0, 16'h00C5, "R7 wr readback");

    acc(0, 0, 3, 16'h0042, 0, 0, "R8 odd value");
    settle();
    chk({15'd0, ctl_enabled}, 0, "R8 odd value ignored");
    acc(0, 0, 3, 16'h0095, 0, 0, "R8 enable");
    settle();
    chk({15'd0, ctl_enabled}, 1, "R8 enabled");
    acc(1, 0, 3, 0, 0, 16'h0095, "R8 read enabled");
    acc(0, 0, 3, 16'h0011, 0, 0, "R8 disable");
    settle();
    chk({15'd0, ctl_enabled}, 0, "R8 disabled");
    acc(0, 0, 3, 16'h0095, 0, 0, "R8 re-enable");

    acc(0, 0, 6, 16'h00FF, 0, 0, "R10 misc all ones");
    settle();
    chk({9'd0, prefetch_en, addr_setup, cmd_delay, drive_sel}, 16'h007F, "R10 fields ones");
    acc(1, 0, 6, 0, 0, 16'h007F, "R10 masked readback");
    acc(0, 0, 6, 16'h002B, 0, 0, "R10 misc pattern");
    settle();
    chk({15'd0, drive_sel}, 1, "R10 drive_sel");
    chk({13'd0, cmd_delay}, 5, "R10 delay");
    chk({14'd0, addr_setup}, 2, "R10 setup");
    chk({15'd0, prefetch_en}, 0, "R10 prefetch");

    strap_slow = 0;
    acc(0, 0, 5, 16'h00FF, 0, 0, "R9 strap write");
    acc(1, 0, 5, 0, 0, 16'h0000, "R9 strap fast, write ignored");
    acc(0, 0, 4, 16'h0055, 0, 0, "R12 spare write");
    acc(1, 0, 4, 0, 0, 16'h0000, "R12 spare still 0");

    acc(0, 0, 2, 16'h0084, 1, 0, "R11 other key forwarded");
    settle();
    chk({15'd0, bank_open}, 1, "R11 stays open");
    acc(0, 0, 2, 16'h0083, 1, 0, "R11 close key");
    settle();
    chk({15'd0, bank_open}, 0, "R11 closed");
    acc(1, 0, 0, 0, 1, 16'hA500, "R11 R6 offset 0 back to task file");

    acc(1, 1, 1, 0, 1, 16'hA501, "R4 probe");
    acc(1, 0, 1, 0, 1, 16'hA501, "R4 byte read aborts");
    acc(1, 1, 1, 0, 1, 16'hA501, "R4 probe");
    acc(0, 0, 2, 16'h0003, 1, 0, "R4 key after one probe");
    settle();
    chk({15'd0, bank_open}, 0, "R4 byte read abort");
    acc(1, 1, 1, 0, 1, 16'hA501, "R4 probe");
    acc(1, 1, 1, 0, 1, 16'hA501, "R4 probe");
    acc(0, 0, 2, 16'h0004, 1, 0, "R4 wrong key aborts");
    acc(0, 0, 2, 16'h0003, 1, 0, "R4 key after abort");
    settle();
    chk({15'd0, bank_open}, 0, "R4 wrong key abort");
    acc(1, 1, 1, 0, 1, 16'hA501, "R4 probe");
    acc(1, 1, 1, 0, 1, 16'hA501, "R4 probe");
    acc(1, 1, 3, 0, 1, 16'hA503, "R4 other offset aborts");
    acc(0, 0, 2, 16'h0003, 1, 0, "R4 key after abort");
    settle();
    chk({15'd0, bank_open}, 0, "R4 offset abort");
    acc(1, 1, 1, 0, 1, 16'hA501, "R4 probe");
    acc(1, 1, 1, 0, 1, 16'hA501, "R4 probe");
    acc(0, 1, 2, 16'h0003, 1, 0, "R4 word key aborts");
    acc(0, 0, 2, 16'h0003, 1, 0, "R4 key after abort");
    settle();
    chk({15'd0, bank_open}, 0, "R4 word key abort");

    acc(1, 1, 1, 0, 1, 16'hA501, "R5 probe");
    acc(1, 1, 1, 0, 1, 16'hA501, "R5 probe");
    acc(1, 1, 1, 0, 1, 16'hA501, "R5 third probe");
    acc(0, 0, 2, 16'h0003, 1, 0, "R5 key");
    settle();
    chk({15'd0, bank_open}, 1, "R5 opened after three probes");

    acc(1, 0, 0, 0, 0, 16'h003A, "R12 rd timing kept");
    acc(1, 0, 3, 0, 0, 16'h0095, "R12 control kept");
    acc(1, 0, 6, 0, 0, 16'h002B, "R12 misc kept");
    settle();
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      nerr++;
      $display("FAIL scoreboard: actual %0d left, expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule